// File: doc/BRIEF.md
# Clock Control Register with Interlocks

This block is the 32-bit control and status word of a clock unit. It turns three clock sources on and off: an internal RC oscillator, an external crystal oscillator and a PLL. It also holds a crystal bypass bit, an enable for the clock-failure detector, and calibration and trim fields for the internal oscillator. Software writes the word over a simple register bus with per-byte strobes. A read returns the word in the same cycle, with no wait states.

Software writes pass through interlocks. The enable of the source that currently drives the system clock cannot be cleared. The bypass bit is frozen while the crystal runs. The calibration field accepts data only when a key input holds the unlock value. Hardware events force enables directly. Entering a low-power state stops the PLL and the crystal. Leaving a low-power state, or a reported crystal failure while the detector is on, restarts the RC oscillator. Three read-only status bits report oscillator readiness. Each is registered from its ready input and qualified by its own enable.

Top module: `clk_ctrl_reg`

## Requirements
- R1: After synchronous reset the word reads `{cal_factory, 8'h83}` in its low 16 bits and zero above. This means trim (bits 7:2) = 6'h20, RC stable (bit 1) = 1, RC enable (bit 0) = 1, and calibration (bits 15:8) = the value on `cal_factory` during reset.
- R2: Bits 31:26 and 23:20 always read 0, and writes to them have no effect.
- R3: A write changes only the bytes whose `wr_be` bit is set. Strobe bit n covers data bits 8n+7:8n. Changes are visible on `rd_data` in the cycle after the write.
- R4: `sysclk_src` selects the source in use: 0 = RC, 1 = crystal, 2 = PLL, 3 = none. A write of 0 to that source's enable bit leaves the bit unchanged. The enable bits are PLL bit 24, crystal bit 16 and RC bit 0.
- R5: `lp_enter` clears the PLL enable and the crystal enable on the next edge. This holds even if the source is in use or a write sets the bit in the same cycle.
- R6: `lp_exit` sets the RC enable on the next edge. `xtal_fail` does the same, but only while the detector enable (bit 19) is 1. Either event overrides a simultaneous write of 0.
- R7: The bypass bit (bit 18) takes written data only while the crystal enable is 0 before the write. Otherwise it keeps its value.
- R8: The calibration field (bits 15:8) takes written data only while `cal_key` equals 8'h5A. Otherwise it keeps its value.
- R9: Each stable bit updates one cycle after its ready input. The stable bits are PLL bit 25, crystal bit 17 and RC bit 1. A stable bit reads 0 whenever its enable reads 0.
- R10: The control outputs always equal the matching fields of `rd_data`. These outputs are the enables, bypass, detector enable, calibration and trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request this cycle |
| wr_be | input | 4 | Byte strobes for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register word |
| pll_ready | input | 1 | PLL lock indication |
| xtal_ready | input | 1 | Crystal oscillator ready |
| rc_ready | input | 1 | RC oscillator ready |
| sysclk_src | input | 2 | Source currently driving the system clock |
| lp_enter | input | 1 | Low-power entry event |
| lp_exit | input | 1 | Low-power exit event |
| xtal_fail | input | 1 | Crystal clock failure event |
| cal_key | input | 8 | Calibration unlock key |
| cal_factory | input | 8 | Factory calibration value loaded at reset |
| pll_en | output | 1 | PLL enable |
| xtal_en | output | 1 | Crystal enable |
| xtal_bypass | output | 1 | Crystal bypass |
| cfd_en | output | 1 | Clock-failure detector enable |
| rc_en | output | 1 | RC oscillator enable |
| rc_cal | output | 8 | RC calibration |
| rc_trim | output | 6 | RC trim |

## Verification
On every cycle the assertions check the hardware overrides, the in-use hold of the enables, and the freezing of bypass and calibration while locked. They also check that no stable bit reads 1 while its enable is 0. The reset value, the byte-lane selection, the one-cycle latency of the stable bits and the cases where a hardware event and a write collide can only be shown by the bench. It steps through those scenarios against its reference model.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int REG_W   = 32;
    localparam int LANES   = REG_W / 8;

    localparam int B_PLL_STBL = 25;
    localparam int B_PLL_EN   = 24;
    localparam int B_CFD_EN   = 19;
    localparam int B_BYPASS   = 18;
    localparam int B_XT_STBL  = 17;
    localparam int B_XT_EN    = 16;
    localparam int CAL_LSB    = 8;
    localparam int CAL_W      = 8;
    localparam int TRIM_LSB   = 2;
    localparam int TRIM_W     = 6;
    localparam int B_RC_STBL  = 1;
    localparam int B_RC_EN    = 0;

    localparam logic [CAL_W-1:0]  CAL_UNLOCK = 8'h5A;
    localparam logic [TRIM_W-1:0] TRIM_RST   = 6'h20;

    typedef enum logic [1:0] {
        SRC_RC   = 2'd0,
        SRC_XTAL = 2'd1,
        SRC_PLL  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef struct packed {
        logic              pll_en;
        logic              cfd_en;
        logic              bypass;
        logic              xt_en;
        logic [CAL_W-1:0]  cal;
        logic [TRIM_W-1:0] trim;
        logic              rc_en;
    } ctrl_t;

    typedef struct packed {
        logic pll;
        logic xt;
        logic rc;
    } stbl_t;

    function automatic logic [REG_W-1:0] pack_word(input ctrl_t c, input stbl_t s);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_PLL_STBL]                 = s.pll;
        w[B_PLL_EN]                   = c.pll_en;
        w[B_CFD_EN]                   = c.cfd_en;
        w[B_BYPASS]                   = c.bypass;
        w[B_XT_STBL]                  = s.xt;
        w[B_XT_EN]                    = c.xt_en;
        w[CAL_LSB +: CAL_W]           = c.cal;
        w[TRIM_LSB +: TRIM_W]         = c.trim;
        w[B_RC_STBL]                  = s.rc;
        w[B_RC_EN]                    = c.rc_en;
        return w;
    endfunction

endpackage

// File: rtl/clkctl_strobe.sv
module clkctl_strobe #(
    parameter int LANES = 4
) (
    input  logic               wr_en,
    input  logic [LANES-1:0]   wr_be,
    output logic [LANES*8-1:0] bit_we
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bit_we[g*8 +: 8] = {8{wr_en & wr_be[g]}};
    end
endmodule

// File: rtl/clkctl_en_bit.sv
module clkctl_en_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic wd,
    input  logic in_use,
    input  logic hw_set,
    input  logic hw_clr,
    output logic q,
    output logic d
);
    always_comb begin
        d = q;
        if (we) begin
            // software may raise the bit, but not drop a source in use
            if (!(in_use && !wd)) d = wd;
        end
        if (hw_set) d = 1'b1;
        if (hw_clr) d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= d;
    end
endmodule

// File: rtl/clkctl_stable.sv
module clkctl_stable #(
    parameter int           N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ready,
    input  logic [N-1:0] en_next,
    output logic [N-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) q[g] <= RST_VAL[g];
            else     q[g] <= ready[g] & en_next[g];
        end
    end
endmodule

// File: rtl/clk_ctrl_reg.sv
module clk_ctrl_reg
    import clkctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        pll_ready,
    input  logic        xtal_ready,
    input  logic        rc_ready,
    input  logic [1:0]  sysclk_src,
    input  logic        lp_enter,
    input  logic        lp_exit,
    input  logic        xtal_fail,
    input  logic [7:0]  cal_key,
    input  logic [7:0]  cal_factory,
    output logic        pll_en,
    output logic        xtal_en,
    output logic        xtal_bypass,
    output logic        cfd_en,
    output logic        rc_en,
    output logic [7:0]  rc_cal,
    output logic [5:0]  rc_trim
);
    logic [REG_W-1:0] bit_we;
    ctrl_t            ctl;
    stbl_t            stb;
    logic             pll_d, xt_d, rc_d;
    logic             rc_hw_set;
    src_e             src;

    assign src = src_e'(sysclk_src);

    clkctl_strobe #(.LANES(LANES)) u_strobe (
        .wr_en (wr_en),
        .wr_be (wr_be),
        .bit_we(bit_we)
    );

    clkctl_en_bit #(.RST_VAL(1'b0)) u_pll_en (
        .clk(clk), .rst(rst),
        .we(bit_we[B_PLL_EN]), .wd(wr_data[B_PLL_EN]),
        .in_use(src == SRC_PLL),
        .hw_set(1'b0), .hw_clr(lp_enter),
        .q(ctl.pll_en), .d(pll_d)
    );

    clkctl_en_bit #(.RST_VAL(1'b0)) u_xt_en (
        .clk(clk), .rst(rst),
        .we(bit_we[B_XT_EN]), .wd(wr_data[B_XT_EN]),
        .in_use(src == SRC_XTAL),
        .hw_set(1'b0), .hw_clr(lp_enter),
        .q(ctl.xt_en), .d(xt_d)
    );

    assign rc_hw_set = lp_exit | (xtal_fail & ctl.cfd_en);

    clkctl_en_bit #(.RST_VAL(1'b1)) u_rc_en (
        .clk(clk), .rst(rst),
        .we(bit_we[B_RC_EN]), .wd(wr_data[B_RC_EN]),
        .in_use(src == SRC_RC),
        .hw_set(rc_hw_set), .hw_clr(1'b0),
        .q(ctl.rc_en), .d(rc_d)
    );

    // plain and interlocked data fields
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.cfd_en <= 1'b0;
            ctl.bypass <= 1'b0;
            ctl.cal    <= cal_factory;
            ctl.trim   <= TRIM_RST;
        end else begin
            if (bit_we[B_CFD_EN])
                ctl.cfd_en <= wr_data[B_CFD_EN];
            if (bit_we[B_BYPASS] && !ctl.xt_en)
                ctl.bypass <= wr_data[B_BYPASS];
            if (bit_we[CAL_LSB] && cal_key == CAL_UNLOCK)
                ctl.cal <= wr_data[CAL_LSB +: CAL_W];
            if (bit_we[TRIM_LSB])
                ctl.trim <= wr_data[TRIM_LSB +: TRIM_W];
        end
    end

    clkctl_stable #(.N(3), .RST_VAL(3'b001)) u_stable (
        .clk    (clk),
        .rst    (rst),
        .ready  ({pll_ready, xtal_ready, rc_ready}),
        .en_next({pll_d, xt_d, rc_d}),
        .q      (stb)
    );

    assign rd_data     = pack_word(ctl, stb);
    assign pll_en      = ctl.pll_en;
    assign xtal_en     = ctl.xt_en;
    assign xtal_bypass = ctl.bypass;
    assign cfd_en      = ctl.cfd_en;
    assign rc_en       = ctl.rc_en;
    assign rc_cal      = ctl.cal;
    assign rc_trim     = ctl.trim;
endmodule

// File: rtl/clk_ctrl_reg_chk.sv
module clk_ctrl_reg_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] rd_data,
    input logic [1:0]  sysclk_src,
    input logic        wr_en,
    input logic [3:0]  wr_be,
    input logic        lp_enter,
    input logic        lp_exit,
    input logic        xtal_fail,
    input logic [7:0]  cal_key,
    input logic        pll_en,
    input logic        xtal_en,
    input logic        xtal_bypass,
    input logic        cfd_en,
    input logic        rc_en,
    input logic [7:0]  rc_cal
);
    p_hold_pll_r4: assert property (@(posedge clk) disable iff (rst)
        (sysclk_src == 2'd2 && pll_en && !lp_enter) |=> pll_en);
    p_hold_xtal_r4: assert property (@(posedge clk) disable iff (rst)
        (sysclk_src == 2'd1 && xtal_en && !lp_enter) |=> xtal_en);
    p_hold_rc_r4: assert property (@(posedge clk) disable iff (rst)
        (sysclk_src == 2'd0 && rc_en) |=> rc_en);
    p_lp_clear_r5: assert property (@(posedge clk) disable iff (rst)
        lp_enter |=> (!pll_en && !xtal_en));
    p_rc_wake_r6: assert property (@(posedge clk) disable iff (rst)
        (lp_exit || (xtal_fail && cfd_en)) |=> rc_en);
    p_bypass_lock_r7: assert property (@(posedge clk) disable iff (rst)
        xtal_en |=> $stable(xtal_bypass));
    p_cal_lock_r8: assert property (@(posedge clk) disable iff (rst)
        (cal_key != 8'h5A || !(wr_en && wr_be[1])) |=> $stable(rc_cal));
    p_stbl_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !(rd_data[25] && !rd_data[24]) && !(rd_data[17] && !rd_data[16])
        && !(rd_data[1] && !rd_data[0]));
endmodule

bind clk_ctrl_reg clk_ctrl_reg_chk u_chk (
    .clk(clk), .rst(rst), .rd_data(rd_data), .sysclk_src(sysclk_src),
    .wr_en(wr_en), .wr_be(wr_be), .lp_enter(lp_enter), .lp_exit(lp_exit),
    .xtal_fail(xtal_fail), .cal_key(cal_key), .pll_en(pll_en),
    .xtal_en(xtal_en), .xtal_bypass(xtal_bypass), .cfd_en(cfd_en),
    .rc_en(rc_en), .rc_cal(rc_cal)
);

// File: tb/clk_ctrl_reg_tb.sv
module clk_ctrl_reg_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [3:0]  wr_be = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic        pll_ready = 0, xtal_ready = 0, rc_ready = 1;
    logic [1:0]  sysclk_src = 2'd0;
    logic        lp_enter = 0, lp_exit = 0, xtal_fail = 0;
    logic [7:0]  cal_key = 0;
    logic [7:0]  cal_factory = 8'hA5;
    logic        pll_en, xtal_en, xtal_bypass, cfd_en, rc_en;
    logic [7:0]  rc_cal;
    logic [5:0]  rc_trim;

    int checks = 0, errors = 0;
    string cur_req = "R1";

    // reference state
    bit m_pll, m_xen, m_byp, m_cfd, m_ren, m_ps, m_xs, m_rs;
    bit [7:0] m_cal;
    bit [5:0] m_trim;

    always #5 clk = ~clk;

    clk_ctrl_reg u_dut (.*);

    function automatic logic [31:0] model_word();
        return {6'b0, m_ps, m_pll, 4'b0, m_cfd, m_byp, m_xs, m_xen,
                m_cal, m_trim, m_rs, m_ren};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_update();
        bit b0, b1, b2, b3;
        bit n_pll, n_xen, n_ren;
        if (rst) begin
            m_pll = 0; m_xen = 0; m_byp = 0; m_cfd = 0; m_ren = 1;
            m_cal = cal_factory; m_trim = 6'd32; m_ps = 0; m_xs = 0; m_rs = 1;
            return;
        end
        b0 = wr_en & wr_be[0]; b1 = wr_en & wr_be[1];
        b2 = wr_en & wr_be[2]; b3 = wr_en & wr_be[3];
        n_pll = m_pll; n_xen = m_xen; n_ren = m_ren;
        if (b3 && (wr_data[24] || sysclk_src != 2'd2)) n_pll = wr_data[24];
        if (b2 && (wr_data[16] || sysclk_src != 2'd1)) n_xen = wr_data[16];
        if (b0 && (wr_data[0]  || sysclk_src != 2'd0)) n_ren = wr_data[0];
        if (lp_enter) begin n_pll = 0; n_xen = 0; end
        if (lp_exit || (xtal_fail && m_cfd)) n_ren = 1;
        if (b2 && !m_xen) m_byp = wr_data[18];
        if (b2) m_cfd = wr_data[19];
        if (b1 && cal_key == 8'h5A) m_cal = wr_data[15:8];
        if (b0) m_trim = wr_data[7:2];
        m_pll = n_pll; m_xen = n_xen; m_ren = n_ren;
        m_ps = pll_ready && n_pll;
        m_xs = xtal_ready && n_xen;
        m_rs = rc_ready && n_ren;
    endtask

    // one clock: model follows the edge, outputs compared mid-cycle
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk(cur_req, rd_data, model_word());
        chk("R10", {pll_en, xtal_en, xtal_bypass, cfd_en, rc_en, rc_cal, rc_trim},
            {m_pll, m_xen, m_byp, m_cfd, m_ren, m_cal, m_trim});
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        wr_en = 1; wr_be = be; wr_data = d;
        step();
        wr_en = 0; wr_be = 0; wr_data = 0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        step(); step();
        rst = 0;
        step();
        @(posedge clk); @(negedge clk);
        model_update();
        chk("R1", rd_data, 32'h0000_A583);

        // R2 reserved bits and R8 locked calibration in a full write
        cur_req = "R2";
        wr(4'hF, 32'hFFFF_FFFF);
        chk("R2", rd_data & 32'hFCF0_0000, 32'h0);
        chk("R8", {24'h0, rc_cal}, 32'hA5);
        chk("R7", {31'h0, xtal_bypass}, 32'h1);

        // R4 RC in use: clear ignored; R3 only lane 0 changes
        cur_req = "R3";
        wr(4'h1, 32'h0000_0000);
        chk("R4", {31'h0, rc_en}, 32'h1);
        chk("R3", {26'h0, rc_trim}, 32'h0);
        chk("R3", {31'h0, pll_en}, 32'h1);

        // R7 bypass locked while crystal runs, free once it stops
        cur_req = "R7";
        wr(4'h4, 32'h0000_0000);
        chk("R7", {31'h0, xtal_bypass}, 32'h1);
        wr(4'h4, 32'h0000_0000);
        chk("R7", {31'h0, xtal_bypass}, 32'h0);

        // R8 unlocked calibration write
        cur_req = "R8";
        cal_key = 8'h5A;
        wr(4'h2, 32'h0000_3C00);
        chk("R8", {24'h0, rc_cal}, 32'h3C);
        cal_key = 8'h5B;
        wr(4'h2, 32'h0000_FF00);
        chk("R8", {24'h0, rc_cal}, 32'h3C);

        // R9 stable bits follow ready one cycle late
        cur_req = "R9";
        pll_ready = 1; xtal_ready = 1;
        step();
        chk("R9", {31'h0, rd_data[25]}, 32'h1);
        chk("R9", {31'h0, rd_data[17]}, 32'h0);
        pll_ready = 0;
        step();
        chk("R9", {31'h0, rd_data[25]}, 32'h0);
        pll_ready = 1;

        // R4 PLL in use, then R5 low-power entry beats set write
        cur_req = "R4";
        sysclk_src = 2'd2;
        wr(4'h8, 32'h0000_0000);
        chk("R4", {31'h0, pll_en}, 32'h1);
        cur_req = "R5";
        lp_enter = 1;
        wr(4'hC, 32'h0101_0000);
        lp_enter = 0;
        chk("R5", {30'h0, pll_en, xtal_en}, 32'h0);

        // R6 RC wake-up paths
        cur_req = "R6";
        sysclk_src = 2'd1;
        wr(4'h1, 32'h0000_0000);
        chk("R6", {31'h0, rc_en}, 32'h0);
        xtal_fail = 1;
        step();
        xtal_fail = 0;
        chk("R6", {31'h0, rc_en}, 32'h0);
        wr(4'h4, 32'h0008_0000);
        xtal_fail = 1;
        step();
        xtal_fail = 0;
        chk("R6", {31'h0, rc_en}, 32'h1);
        wr(4'h1, 32'h0000_0000);
        lp_exit = 1;
        wr(4'h1, 32'h0000_0000);
        lp_exit = 0;
        chk("R6", {31'h0, rc_en}, 32'h1);

        // R4 crystal in use keeps its enable
        cur_req = "R4";
        wr(4'h4, 32'h0001_0000);
        wr(4'h4, 32'h0000_0000);
        chk("R4", {31'h0, xtal_en}, 32'h1);
        sysclk_src = 2'd3;
        wr(4'h4, 32'h0000_0000);
        chk("R4", {31'h0, xtal_en}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule